// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block is a clocked front end for an external asynchronous static RAM of 256K words by 16 bits. Single read and write requests arrive over a valid/ready handshake: an 18-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns each request into a fixed sequence of registered, glitch-free memory pins. These pins are an address bus, an active-low chip select, an output enable, a write strobe and one active-low select per byte lane. The sequence is timed in whole clock cycles, so the memory's access, strobe-width and cycle-length minimums are met.

The bidirectional data bus is split into an output value, an output-enable and an input. A write is framed by the write strobe. Address, chip select and lane selects settle one cycle before the strobe falls, and they stay put for one cycle after it rises. After every read, one turnaround cycle with the memory deselected lets the memory's outputs float before the controller can drive the bus. Read data is captured on the last read cycle and returned with a one-cycle valid pulse. Lanes that the mask did not select come back as zero. Between requests the memory is held in standby.

Cycle counts come from nanosecond parameters and the clock period, each rounded up. At the default 10 ns period a read holds the bus for 2 cycles and the write strobe lasts 2 cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active and whenever idle, mem_cs_n, mem_oe_n, mem_we_n and both mem_bs_n bits are 1 and mem_dq_oe is 0. req_ready is 0 during reset and 1 when idle.
- R2: A read accepted in cycle a drives mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_addr equal to the request address in cycles a+1 through a+RD (RD is 2 at defaults).
- R3: mem_bs_n[0] (lanes bits 7:0) and mem_bs_n[1] (bits 15:8) are each 0 during a request's cycles exactly when mask bit 0 or bit 1 is 1. Both are 1 whenever mem_cs_n is 1.
- R4: rsp_valid is 1 for exactly one cycle, the cycle after the last read cycle. In that cycle rsp_data holds the memory word, with every lane whose mask bit is 0 forced to zero.
- R5: A write accepted in cycle a gives one setup cycle (mem_cs_n=0, mem_oe_n=1, mem_we_n=1), then WP cycles with mem_we_n=0 (WP is 2 at defaults), then one recovery cycle with mem_we_n=1. mem_dq_o carries the write data in all of these cycles.
- R6: mem_dq_oe is 1 exactly in a write's setup, strobe and recovery cycles. It is never 1 while mem_oe_n is 0.
- R7: After the last read cycle comes one turnaround cycle with mem_cs_n=1, mem_oe_n=1, mem_dq_oe=0 and req_ready=0. The controller is idle after that.
- R8: A request is taken only in a cycle with req_valid=1 and req_ready=1. req_ready stays 0 from the cycle after acceptance until the return to idle, and a request presented while req_ready is 0 has no effect.
- R9: A write with mask 00 leaves the memory word unchanged.
- R10: mem_addr and mem_dq_o do not change in any cycle where mem_we_n is 0, or in the cycle right after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address pins |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_bs_n | output | 2 | Lane selects, active low, bit 0 low byte |
| mem_dq_o | output | 16 | Data bus value driven by the controller |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_dq_i | input | 16 | Data bus value seen by the controller |

## Verification
The read response pulse falls in the same cycle as the bus turnaround. A new request may also be waiting at the handshake in that cycle. The bench provokes this overlap by holding req_valid high with different fields through a read and then through the write that follows it. Every cycle is compared against a behavioural schedule: the pulse and data must appear only in the deselected turnaround cycle, the held request must not start a second sequence, and a later readback must show the memory untouched by the held fields.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_TURN  = 3'd2,
    ST_SETUP = 3'd3,
    ST_PULSE = 3'd4,
    ST_RECOV = 3'd5
  } seq_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_rstsync.sv
module sram_lane_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             is_write,
  input  logic             expired,
  output seq_state_e       state_q,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (fire) begin
          if (is_write) begin
            state_d = ST_SETUP;
          end else begin
            state_d  = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = RD_LOAD;
          end
        end
      end
      ST_READ: begin
        if (expired) begin
          state_d = ST_TURN;
        end
      end
      ST_TURN: begin
        state_d = ST_IDLE;
      end
      ST_SETUP: begin
        state_d  = ST_PULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LOAD;
      end
      ST_PULSE: begin
        if (expired) begin
          state_d = ST_RECOV;
        end
      end
      ST_RECOV: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_lane_rdcap.sv
module sram_lane_rdcap #(
  parameter int LANES  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign masked[8*i +: 8] = lane_en[i] ? bus_in[8*i +: 8] : 8'h00;
  end

  always_comb begin
    data_d = data_q;
    if (capture) begin
      data_d = masked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= capture;
      data_q  <= data_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 12,
  parameter int T_AA_NS = 12,
  parameter int T_WP_NS = 8,
  parameter int T_WC_NS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_bs_n,
  output logic [DATA_W-1:0]     mem_dq_o,
  output logic                  mem_dq_oe,
  input  logic [DATA_W-1:0]     mem_dq_i
);

  localparam int LANES  = DATA_W / 8;
  localparam int RD_CYC = ceil_div(max2(T_RC_NS, T_AA_NS), CLK_NS);
  localparam int WP_CYC = max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_WC_NS, CLK_NS));
  localparam int CNT_W  = $clog2(max2(RD_CYC, WP_CYC) + 1);

  logic             srst_n;
  logic             fire;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  seq_state_e       state_q;
  seq_state_e       state_d;
  logic             capture;

  logic [ADDR_W-1:0] addr_q,  addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic [LANES-1:0]  mask_q,  mask_d;

  logic             active_d;
  logic             drive_d;
  logic             cs_n_q,  cs_n_d;
  logic             oe_n_q,  oe_n_d;
  logic             we_n_q,  we_n_d;
  logic [LANES-1:0] bs_n_q,  bs_n_d;
  logic             doe_q,   doe_d;
  logic             ready_q, ready_d;

  sram_lane_rstsync u_rstsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign fire = req_valid && ready_q;

  sram_lane_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  sram_lane_seq #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (srst_n),
    .fire     (fire),
    .is_write (req_write),
    .expired  (expired),
    .state_q  (state_q),
    .state_d  (state_d),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val)
  );

  // Request capture, enabled by acceptance
  always_comb begin
    addr_d  = addr_q;
    wdata_d = wdata_q;
    mask_d  = mask_q;
    if (fire) begin
      addr_d  = req_addr;
      wdata_d = req_wdata;
      mask_d  = req_mask;
    end
  end

  // Pin values follow the next state so that every pin leaves a flop
  always_comb begin
    active_d = (state_d == ST_READ)  || (state_d == ST_SETUP) ||
               (state_d == ST_PULSE) || (state_d == ST_RECOV);
    drive_d  = (state_d == ST_SETUP) || (state_d == ST_PULSE) ||
               (state_d == ST_RECOV);
    cs_n_d   = !active_d;
    oe_n_d   = (state_d != ST_READ);
    we_n_d   = (state_d != ST_PULSE);
    doe_d    = drive_d;
    ready_d  = (state_d == ST_IDLE);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_bs
    assign bs_n_d[i] = !(active_d && mask_d[i]);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      cs_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      bs_n_q  <= '1;
      doe_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      mask_q  <= mask_d;
      cs_n_q  <= cs_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      bs_n_q  <= bs_n_d;
      doe_q   <= doe_d;
      ready_q <= ready_d;
    end
  end

  assign capture = (state_q == ST_READ) && expired;

  sram_lane_rdcap #(
    .LANES  (LANES),
    .DATA_W (DATA_W)
  ) u_rdcap (
    .clk       (clk),
    .rst_n     (srst_n),
    .capture   (capture),
    .lane_en   (mask_q),
    .bus_in    (mem_dq_i),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign req_ready = ready_q;
  assign mem_addr  = addr_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_bs_n  = bs_n_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = doe_q;

endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_bs_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe)); // R1

  AST_READ_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n)); // R2

  AST_LANES_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> (mem_bs_n == '1)); // R3

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4

  AST_STROBE_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe)); // R5

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n)); // R6

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_cs_n && !mem_dq_oe && !req_ready)); // R7

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8

  AST_ADDR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o))); // R10

endmodule

bind sram_lane_ctrl sram_lane_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LANES  (DATA_W / 8)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_bs_n  (mem_bs_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
module sram_lane_ctrl_bench;

  localparam int CLK_NS = 10;
  localparam int RD_N   = (12 + CLK_NS - 1) / CLK_NS;
  localparam int WP_A   = (8 + CLK_NS - 1) / CLK_NS;
  localparam int WP_B   = (12 + CLK_NS - 1) / CLK_NS;
  localparam int WP_N   = (WP_A > WP_B) ? WP_A : WP_B;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] mem_addr;
  logic        mem_cs_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [1:0]  mem_bs_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i;

  sram_lane_ctrl u_sram_lane_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_bs_n  (mem_bs_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_i  (mem_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit armed = 0;
  bit cur_idle = 0;

  typedef struct {
    logic        cs_n, oe_n, we_n;
    logic [1:0]  bs_n;
    logic        doe, rdy, vld;
    logic [17:0] addr;
    logic [15:0] dout, rdat;
    string       tag, atag, vtag;
  } exp_t;

  exp_t q[$];

  logic [15:0] ram     [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] ram_get(input int a);
    return ram.exists(a) ? ram[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_get(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  // Memory model: a lane floats to 8'hEE unless it is read-enabled
  logic [15:0] ram_word;
  always @* begin
    ram_word = ram_get(int'(mem_addr));
    for (int i = 0; i < 2; i++) begin
      mem_dq_i[8*i +: 8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_bs_n[i]) ?
                           ram_word[8*i +: 8] : 8'hEE;
    end
  end

  always @(negedge clk) begin
    logic [15:0] w;
    if (rst_n && !mem_cs_n && !mem_we_n && (mem_bs_n != 2'b11)) begin
      w = ram_get(int'(mem_addr));
      for (int i = 0; i < 2; i++) begin
        if (!mem_bs_n[i]) w[8*i +: 8] = mem_dq_o[8*i +: 8];
      end
      ram[int'(mem_addr)] = w;
      if (!mem_dq_oe) begin
        n_bad++;
        $display("FAIL R6 write strobe without bus drive: actual %b expected 1", mem_dq_oe);
      end
    end
    if (rst_n && mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n) begin
      n_bad++;
      $display("FAIL R6 bus contention: actual oe_n %b expected 1", mem_oe_n);
    end
  end

  task automatic cmp(input string tag, input string nm, input logic [31:0] act,
                     input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", tag, nm, cyc, act, exp);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 1; e.oe_n = 1; e.we_n = 1; e.bs_n = 2'b11;
    e.doe = 0; e.rdy = 1; e.vld = 0; e.addr = '0; e.dout = '0; e.rdat = '0;
    e.tag = "R1"; e.atag = "R1"; e.vtag = "R4";
    return e;
  endfunction

  task automatic tick();
    exp_t e;
    @(negedge clk);
    cyc++;
    if (armed) begin
      if (q.size() > 0) begin
        e = q.pop_front();
        cur_idle = 0;
      end else begin
        e = idle_e();
        cur_idle = 1;
      end
      n_vec++;
      cmp(e.tag, "cs_n", 32'(mem_cs_n), 32'(e.cs_n));
      cmp(e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
      cmp(e.tag, "we_n", 32'(mem_we_n), 32'(e.we_n));
      cmp("R3", "bs_n", 32'(mem_bs_n), 32'(e.bs_n));
      cmp("R6", "dq_oe", 32'(mem_dq_oe), 32'(e.doe));
      cmp("R8", "ready", 32'(req_ready), 32'(e.rdy));
      cmp("R4", "rsp_valid", 32'(rsp_valid), 32'(e.vld));
      if (e.vld) cmp(e.vtag, "rsp_data", 32'(rsp_data), 32'(e.rdat));
      if (!e.cs_n) cmp(e.atag, "addr", 32'(mem_addr), 32'(e.addr));
      if (e.doe) cmp("R5", "dq_o", 32'(mem_dq_o), 32'(e.dout));
    end
  endtask

  task automatic push_read(input logic [17:0] a, input logic [1:0] m, input string vt);
    exp_t e;
    logic [15:0] w;
    e = idle_e();
    e.cs_n = 0; e.oe_n = 0; e.bs_n = ~m; e.rdy = 0; e.addr = a;
    e.tag = "R2"; e.atag = "R2";
    for (int k = 0; k < RD_N; k++) q.push_back(e);
    w = ref_get(int'(a));
    if (!m[0]) w[7:0] = 8'h00;
    if (!m[1]) w[15:8] = 8'h00;
    e = idle_e();
    e.rdy = 0; e.vld = 1; e.rdat = w; e.tag = "R7"; e.vtag = vt;
    q.push_back(e);
  endtask

  task automatic push_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    exp_t e;
    logic [15:0] w;
    e = idle_e();
    e.cs_n = 0; e.bs_n = ~m; e.doe = 1; e.rdy = 0; e.addr = a; e.dout = d;
    e.tag = "R5"; e.atag = "R10";
    q.push_back(e);
    e.we_n = 0;
    for (int k = 0; k < WP_N; k++) q.push_back(e);
    e.we_n = 1;
    q.push_back(e);
    w = ref_get(int'(a));
    if (m[0]) w[7:0] = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    ref_mem[int'(a)] = w;
  endtask

  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input string vt, input bit hold);
    while (!cur_idle) tick();
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    if (wr) push_write(a, d, m);
    else    push_read(a, m, vt);
    if (hold) begin
      // R8: a request held during the busy cycles must be ignored
      do begin
        tick();
        req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
      end while (q.size() > 0);
      req_valid = 0;
    end else begin
      tick();
      req_valid = 0;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] l;
    bit seen;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_vec++;
    cmp("R1", "cs_n", 32'(mem_cs_n), 32'd1);
    cmp("R1", "oe_n", 32'(mem_oe_n), 32'd1);
    cmp("R1", "we_n", 32'(mem_we_n), 32'd1);
    cmp("R1", "bs_n", 32'(mem_bs_n), 32'd3);
    cmp("R1", "dq_oe", 32'(mem_dq_oe), 32'd0);
    cmp("R1", "ready", 32'(req_ready), 32'd0);
    rst_n = 1;
    seen = 0;
    for (int k = 0; k < 8 && !seen; k++) begin
      @(negedge clk);
      if (req_ready) seen = 1;
    end
    if (!seen) begin
      n_bad++;
      $display("FAIL R1 ready after reset: actual 0 expected 1");
    end
    armed = 1;
    cur_idle = 1;
    tick();

    // R2 R4 full-word write then readback
    issue(1, 18'h00010, 16'h1234, 2'b11, "R4", 0);
    issue(0, 18'h00010, 16'h0000, 2'b11, "R4", 0);
    // R3 lower lane only
    issue(1, 18'h00010, 16'hABCD, 2'b01, "R3", 0);
    issue(0, 18'h00010, 16'h0000, 2'b11, "R3", 0);
    // R3 upper lane only, then partial reads zero the other lane (R4)
    issue(1, 18'h00010, 16'h5AFF, 2'b10, "R3", 0);
    issue(0, 18'h00010, 16'h0000, 2'b01, "R4", 0);
    issue(0, 18'h00010, 16'h0000, 2'b10, "R4", 0);
    // R9 write with no lanes leaves memory intact
    issue(1, 18'h00010, 16'hFFFF, 2'b00, "R9", 0);
    issue(0, 18'h00010, 16'h0000, 2'b11, "R9", 0);
    // R4 read with no lanes returns zero
    issue(0, 18'h00010, 16'h0000, 2'b00, "R4", 0);
    // address extremes
    issue(1, 18'h3FFFF, 16'hC3A5, 2'b11, "R2", 0);
    issue(1, 18'h00000, 16'h0F0F, 2'b11, "R2", 0);
    issue(0, 18'h3FFFF, 16'h0000, 2'b11, "R2", 0);
    issue(0, 18'h00000, 16'h0000, 2'b11, "R2", 0);
    // R7 read immediately followed by write
    issue(0, 18'h00010, 16'h0000, 2'b11, "R7", 0);
    issue(1, 18'h00020, 16'h7E81, 2'b11, "R7", 0);
    // R8 requests held while busy
    issue(0, 18'h00020, 16'h0000, 2'b11, "R8", 1);
    issue(1, 18'h00021, 16'h1111, 2'b11, "R8", 1);
    issue(0, 18'h3FFDF, 16'h0000, 2'b11, "R8", 0);
    issue(0, 18'h00021, 16'h0000, 2'b11, "R8", 0);
    issue(0, 18'h00020, 16'h0000, 2'b11, "R8", 0);

    l = 32'h2468ACE1;
    for (int n = 0; n < 60; n++) begin
      l = l ^ (l << 13);
      l = l ^ (l >> 17);
      l = l ^ (l << 5);
      issue(l[0], l[1] ? {14'h3FFF, l[5:2]} : {14'h0000, l[5:2]}, l[31:16], l[7:6],
            "R4", l[8] & l[9]);
    end
    while (!cur_idle) tick();
    repeat (4) tick();
    finish_run();
  end

endmodule